// File: doc/BRIEF.md
# T1 Framing Loss Monitor

This block watches the framing-bit comparisons of a T1 receiver and declares loss of frame when too many framing bits in a recent window were wrong. The framing detector upstream presents one result per framing bit: a valid strobe plus a mismatch flag that says whether the bit disagreed with the expected framing pattern. The monitor keeps a short shift history of these error flags. It raises an out-of-frame level once at least two errors sit among the newest N framing bits.

A two-bit select input chooses the window length N at run time. Codes 00, 01 and 10 give windows of 4, 5 and 6 bits, and code 11 acts the same as 10. The out-of-frame level stays set until the resync input is asserted. Resync also wipes the history, so a fresh frame search starts clean. A one-cycle event pulse marks each rising edge of the level.

Top module: `t1_oof_monitor`

## Requirements
- R1: After reset, oofLevel and oofPulse are 0, the error history is empty, and the registered window select is 00.
- R2: With winSel = 00, oofLevel rises when 2 of the newest 4 framing bits carry mismatch = 1. An error 5 bits back does not count.
- R3: With winSel = 01, 2 mismatches among the newest 5 framing bits set oofLevel. An error 6 bits back does not count.
- R4: With winSel = 10, 2 mismatches among the newest 6 framing bits set oofLevel.
- R5: winSel = 11 gives the same 6-bit window as 10. An error 7 bits back does not count.
- R6: The history shifts only in a cycle with fbValid = 1. Mismatch values presented while fbValid = 0 are ignored.
- R7: oofLevel is sticky: further framing bits, including error-free ones, do not clear it. Only resync clears it.
- R8: oofPulse is high for exactly one cycle, the same cycle in which oofLevel first reads 1. oofLevel reads 1 in the cycle after the clock edge that stored the deciding framing bit.
- R9: resync clears oofLevel and the whole history at the next edge. If a framing bit arrives in the same cycle as resync, that bit is discarded.
- R10: A change of winSel is registered at the next edge and takes effect at the edge after that. The history is not flushed, and the stored flags are recounted under the new window.
- R11: A single error within the window never sets oofLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fbValid | input | 1 | One framing-bit result is presented this cycle |
| fbMismatch | input | 1 | 1 = framing bit disagreed with expected pattern |
| winSel | input | 2 | Window select: 00=4, 01=5, 10=6, 11=6 bits |
| resync | input | 1 | Clear out-of-frame state and history |
| oofLevel | output | 1 | Sticky out-of-frame indication |
| oofPulse | output | 1 | One-cycle pulse on rising edge of oofLevel |

## Verification
Two functions can fall in the same cycle: a resync and an incoming framing bit. The same holds for a resync and a history that already meets the threshold. The bench provokes the first case by driving resync together with a mismatching valid bit. It then shows that the bit was discarded: one further error must not declare loss of frame, and a second one must. For the second case, the bench builds a history with two errors and applies resync in the same cycle. It then confirms that neither the level nor the pulse appears.

// File: rtl/oof_mon_pkg.sv
package oof_mon_pkg;

  // Strobes passed from the control module to the history datapath
  typedef struct packed {
    logic shiftEn;   // store one framing-bit result
    logic clearHist; // wipe all stored flags (wins over shiftEn)
  } histCtrl_t;

endpackage

// File: rtl/oof_hist_path.sv
module oof_hist_path
  import oof_mon_pkg::*;
#(
  parameter int HIST_DEPTH = 6,
  parameter int BASE_WIN   = 4,
  parameter int SEL_W      = 2,
  localparam int CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  histCtrl_t             ctrl,
  input  logic                  bitErr,
  input  logic [SEL_W-1:0]      selReg,
  output logic [HIST_DEPTH-1:0] histBits,
  output logic [CNT_W-1:0]      errCount
);

  logic [HIST_DEPTH-1:0] hist;
  logic [HIST_DEPTH-1:0] winMask;
  int                    winLen;

  // Window length: base plus select code, capped at the history depth
  always_comb begin
    winLen = BASE_WIN + int'(selReg);
    if (winLen > HIST_DEPTH) winLen = HIST_DEPTH;
  end

  // Bit 0 holds the newest flag; bit i is i framing bits older
  genvar gi;
  generate
    for (gi = 0; gi < HIST_DEPTH; gi++) begin : g_mask
      assign winMask[gi] = (gi < winLen);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else if (ctrl.clearHist) begin
      hist <= '0;
    end else if (ctrl.shiftEn) begin
      hist <= {hist[HIST_DEPTH-2:0], bitErr};
    end
  end

  always_comb begin
    errCount = '0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      errCount = errCount + CNT_W'(hist[i] & winMask[i]);
    end
  end

  assign histBits = hist;

endmodule

// File: rtl/oof_ctrl.sv
module oof_ctrl
  import oof_mon_pkg::*;
#(
  parameter int HIST_DEPTH = 6,
  parameter int ERR_THRESH = 2,
  parameter int SEL_W      = 2,
  localparam int CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fbValid,
  input  logic             resync,
  input  logic [SEL_W-1:0] winSel,
  input  logic [CNT_W-1:0] errCount,
  output histCtrl_t        ctrl,
  output logic [SEL_W-1:0] selReg,
  output logic             oofLevel,
  output logic             oofPulse
);

  logic overLimit;

  assign overLimit      = (errCount >= CNT_W'(ERR_THRESH));
  assign ctrl.clearHist = resync;
  assign ctrl.shiftEn   = fbValid & ~resync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else begin
      selReg <= winSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oofLevel <= 1'b0;
      oofPulse <= 1'b0;
    end else if (resync) begin
      oofLevel <= 1'b0;
      oofPulse <= 1'b0;
    end else begin
      oofPulse <= overLimit & ~oofLevel;
      if (overLimit) oofLevel <= 1'b1;
    end
  end

endmodule

// File: rtl/t1_oof_monitor.sv
module t1_oof_monitor
  import oof_mon_pkg::*;
#(
  parameter int HIST_DEPTH = 6,
  parameter int BASE_WIN   = 4,
  parameter int ERR_THRESH = 2,
  parameter int SEL_W      = 2,
  localparam int CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fbValid,
  input  logic       fbMismatch,
  input  logic [1:0] winSel,
  input  logic       resync,
  output logic       oofLevel,
  output logic       oofPulse
);

  histCtrl_t             ctrl;
  logic [SEL_W-1:0]      selReg;
  logic [CNT_W-1:0]      errCount;
  logic [HIST_DEPTH-1:0] histBits;

  oof_ctrl #(
    .HIST_DEPTH(HIST_DEPTH),
    .ERR_THRESH(ERR_THRESH),
    .SEL_W(SEL_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .fbValid(fbValid),
    .resync(resync),
    .winSel(winSel),
    .errCount(errCount),
    .ctrl(ctrl),
    .selReg(selReg),
    .oofLevel(oofLevel),
    .oofPulse(oofPulse)
  );

  oof_hist_path #(
    .HIST_DEPTH(HIST_DEPTH),
    .BASE_WIN(BASE_WIN),
    .SEL_W(SEL_W)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .bitErr(fbMismatch),
    .selReg(selReg),
    .histBits(histBits),
    .errCount(errCount)
  );

endmodule

// File: rtl/t1_oof_monitor_chk.sv
module t1_oof_monitor_chk #(
  parameter int HIST_DEPTH = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  fbValid,
  input logic                  resync,
  input logic                  oofLevel,
  input logic                  oofPulse,
  input logic [HIST_DEPTH-1:0] histBits
);

  p_pulse_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    oofPulse |-> (oofLevel && !$past(oofLevel)));

  p_rise_gives_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oofLevel) |-> oofPulse);

  p_level_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (oofLevel && !resync) |=> oofLevel);

  p_resync_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (!oofLevel && !oofPulse && histBits == '0));

  p_idle_holds_hist_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!fbValid && !resync) |=> $stable(histBits));

  p_resync_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(resync) |-> !oofPulse);

endmodule

bind t1_oof_monitor t1_oof_monitor_chk #(.HIST_DEPTH(HIST_DEPTH)) uChk (
  .clk(clk),
  .rstN(rstN),
  .fbValid(fbValid),
  .resync(resync),
  .oofLevel(oofLevel),
  .oofPulse(oofPulse),
  .histBits(histBits)
);

// File: tb/t1_oof_monitor_test.sv
`timescale 1ns/1ps
module t1_oof_monitor_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fbValid = 1'b0;
  logic       fbMismatch = 1'b0;
  logic [1:0] winSel = 2'b00;
  logic       resync = 1'b0;
  logic       oofLevel;
  logic       oofPulse;

  int nChecks = 0;
  int nErrs   = 0;

  always #2 clk = ~clk; // 250 MHz

  t1_oof_monitor uut (
    .clk(clk),
    .rstN(rstN),
    .fbValid(fbValid),
    .fbMismatch(fbMismatch),
    .winSel(winSel),
    .resync(resync),
    .oofLevel(oofLevel),
    .oofPulse(oofPulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendBit(input logic err);
    @(negedge clk);
    fbValid = 1'b1;
    fbMismatch = err;
    @(negedge clk);
    fbValid = 1'b0;
    fbMismatch = 1'b0;
  endtask

  task automatic doResync();
    @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  task automatic startWith(input logic [1:0] sel);
    @(negedge clk);
    winSel = sel;
    doResync();
    tick();
  endtask

  task automatic testReset();
    check("R1 level after reset", oofLevel, 1'b0);
    check("R1 pulse after reset", oofPulse, 1'b0);
    // Registered select is 00: E,G,G,E declares (4-bit window)
    sendBit(1); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R1 default window 4", oofLevel, 1'b1);
  endtask

  task automatic testWin4();
    startWith(2'b00);
    sendBit(1); sendBit(0); sendBit(0); tick();
    check("R11 single error quiet", oofLevel, 1'b0);
    sendBit(1); tick();
    check("R2 2 of 4 declares", oofLevel, 1'b1);
    startWith(2'b00);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R2 error 5 back excluded", oofLevel, 1'b0);
  endtask

  task automatic testWin5();
    startWith(2'b01);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R3 2 of 5 declares", oofLevel, 1'b1);
    startWith(2'b01);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R3 error 6 back excluded", oofLevel, 1'b0);
  endtask

  task automatic testWin6();
    startWith(2'b10);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R4 2 of 6 declares", oofLevel, 1'b1);
    startWith(2'b11);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R5 code 11 window 6", oofLevel, 1'b1);
    startWith(2'b11);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R5 error 7 back excluded", oofLevel, 1'b0);
  endtask

  task automatic testIdleIgnored();
    startWith(2'b00);
    sendBit(1);
    @(negedge clk);
    fbMismatch = 1'b1;
    for (int i = 0; i < 10; i++) tick();
    fbMismatch = 1'b0;
    check("R6 invalid mismatches ignored", oofLevel, 1'b0);
    sendBit(1); tick();
    check("R6 stored error kept", oofLevel, 1'b1);
  endtask

  task automatic testStickyPulse();
    startWith(2'b00);
    sendBit(1);
    @(negedge clk);
    fbValid = 1'b1; fbMismatch = 1'b1;
    @(negedge clk);
    fbValid = 1'b0; fbMismatch = 1'b0;
    check("R8 level not before next edge", oofLevel, 1'b0);
    tick();
    check("R8 level rises", oofLevel, 1'b1);
    check("R8 pulse with level", oofPulse, 1'b1);
    tick();
    check("R8 pulse one cycle", oofPulse, 1'b0);
    for (int i = 0; i < 8; i++) sendBit(0);
    tick();
    check("R7 level sticky", oofLevel, 1'b1);
    check("R8 no repeat pulse", oofPulse, 1'b0);
    doResync();
    check("R7 resync clears level", oofLevel, 1'b0);
  endtask

  task automatic testResyncCollide();
    // Resync against a history that meets the threshold
    startWith(2'b00);
    sendBit(1);
    @(negedge clk);
    fbValid = 1'b1; fbMismatch = 1'b1;
    @(negedge clk);
    fbValid = 1'b0; fbMismatch = 1'b0; resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check("R9 resync beats threshold level", oofLevel, 1'b0);
    check("R9 resync beats threshold pulse", oofPulse, 1'b0);
    tick();
    check("R9 history wiped", oofLevel, 1'b0);
    // Resync together with an error bit: the bit is discarded
    sendBit(1);
    @(negedge clk);
    resync = 1'b1; fbValid = 1'b1; fbMismatch = 1'b1;
    @(negedge clk);
    resync = 1'b0; fbValid = 1'b0; fbMismatch = 1'b0;
    sendBit(1); tick();
    check("R9 coincident bit discarded", oofLevel, 1'b0);
    sendBit(1); tick();
    check("R9 counting resumes", oofLevel, 1'b1);
  endtask

  task automatic testSelChange();
    startWith(2'b00);
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(1); tick();
    check("R10 narrow window quiet", oofLevel, 1'b0);
    @(negedge clk);
    winSel = 2'b01;
    tick();
    check("R10 no effect after one edge", oofLevel, 1'b0);
    tick();
    check("R10 recount without flush", oofLevel, 1'b1);
  endtask

  initial begin
    #(4 * 100000);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testWin4();
    testWin5();
    testWin6();
    testIdleIgnored();
    testStickyPulse();
    testResyncCollide();
    testSelChange();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule